// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block turns two external interrupt pins into interrupt requests for the CPU. Each pin has its own two-bit sense mode, which selects low-level, falling-edge or rising-edge triggering. Each pin also has an enable and an acknowledge strobe that the vectoring logic pulses when it takes the interrupt. The pin value passes through a synchronizer before it is used. The block samples the pin no matter how the pad direction is set, so software that drives the pin as an output can raise its own interrupt.

In low-level mode the request follows the synchronized pin and nothing is stored. In the two edge modes a detected edge sets a per-pin flag. The request stays up until the acknowledge clears that flag. The enable only gates the request, so an edge that arrives while a pin is disabled is still recorded.

Top module: `extint_sense`

## Requirements
- R1: While reset is asserted and right after it is released, `irqReq` is all zero. The synchronizer and edge history reset to the pin-high state.
- R2: Mode 2'b00 (low level) raises the pin's request two clock edges after the pin goes low. The request drops two edges after the pin goes high again. Nothing is latched.
- R3: Mode 2'b10 (falling edge) sets the pin's request on the third clock edge after a high-to-low change. The request stays set after the pin returns high.
- R4: Mode 2'b11 (rising edge) sets the pin's request on the third clock edge after a low-to-high change. The request stays set.
- R5: In an edge mode, an acknowledge pulse clears the latched request at the next clock edge.
- R6: When an acknowledge and a newly detected edge meet on the same clock edge, the new edge wins and the request stays set.
- R7: Mode 2'b01 is reserved. It never raises a request, and it stores no flag that shows up after a later switch to an edge mode.
- R8: A cleared enable forces the pin's request low. An edge seen while the pin is disabled is still latched, and it shows as soon as the enable is set.
- R9: The two pins are independent. Activity, mode and acknowledge on one pin never change the other pin's request.
- R10: An edge of the opposite polarity to the selected edge mode sets no request.
- R11: In low-level mode an acknowledge has no effect on the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pinIn | input | NumPins | Raw pin levels, sampled whatever the pad direction |
| senseMode | input | 2*NumPins | Per-pin sense mode; bits [2i+1:2i] belong to pin i |
| irqEnable | input | NumPins | Per-pin request enable |
| irqAck | input | NumPins | Per-pin acknowledge strobe from the vectoring logic |
| irqReq | output | NumPins | Per-pin interrupt request |

## Verification
The setting of a latched flag by a fresh edge and its clearing by an acknowledge can fall on the same clock edge. The bench provokes this by dropping a pin in falling mode and then raising the acknowledge for exactly the cycle in which the edge reaches the flag. The design is judged right only if the request is still high after that edge and is cleared by a later acknowledge. A second overlap is one pin's acknowledge landing while the other pin's flag is set. The bench checks that only the acknowledged pin drops.

// File: rtl/extint_pkg.sv
package extint_pkg;

  typedef enum logic [1:0] {
    SenseLow  = 2'b00,
    SenseRsvd = 2'b01,
    SenseFall = 2'b10,
    SenseRise = 2'b11
  } senseMode_e;

  // Per-pin strobes from control to datapath
  typedef struct packed {
    logic setFlag;
    logic clrFlag;
    logic levelSel;
    logic edgeSel;
  } pinStrobe_t;

endpackage

// File: rtl/extint_control.sv
module extint_control
  import extint_pkg::*;
#(
  parameter int NumPins = 2
) (
  input  logic [2*NumPins-1:0]        senseMode,
  input  logic [NumPins-1:0]          irqAck,
  input  logic [NumPins-1:0]          syncNow,
  input  logic [NumPins-1:0]          syncPrev,
  output pinStrobe_t [NumPins-1:0]    strobes
);

  for (genvar g = 0; g < NumPins; g++) begin : g_pin
    senseMode_e mode;
    logic fell;
    logic rose;

    always_comb begin
      mode = senseMode_e'(senseMode[2*g +: 2]);
      fell = syncPrev[g] & ~syncNow[g];
      rose = ~syncPrev[g] & syncNow[g];
      strobes[g].levelSel = (mode == SenseLow);
      strobes[g].edgeSel  = (mode == SenseFall) || (mode == SenseRise);
      strobes[g].setFlag  = ((mode == SenseFall) && fell) ||
                            ((mode == SenseRise) && rose);
      strobes[g].clrFlag  = irqAck[g] && strobes[g].edgeSel;
    end
  end

endmodule

// File: rtl/extint_datapath.sv
module extint_datapath
  import extint_pkg::*;
#(
  parameter int NumPins    = 2,
  parameter int SyncStages = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NumPins-1:0]       pinIn,
  input  logic [NumPins-1:0]       irqEnable,
  input  pinStrobe_t [NumPins-1:0] strobes,
  output logic [NumPins-1:0]       syncNow,
  output logic [NumPins-1:0]       syncPrev,
  output logic [NumPins-1:0]       irqReq
);

  localparam int SyncMsb = SyncStages - 1;

  for (genvar g = 0; g < NumPins; g++) begin : g_pin
    logic [SyncMsb:0] chain;
    logic             prevQ;
    logic             flagQ;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '1;
        prevQ <= 1'b1;
        flagQ <= 1'b0;
      end else begin
        chain <= {chain[SyncMsb-1:0], pinIn[g]};
        prevQ <= chain[SyncMsb];
        if (strobes[g].setFlag)      flagQ <= 1'b1;
        else if (strobes[g].clrFlag) flagQ <= 1'b0;
      end
    end

    always_comb begin
      syncNow[g]  = chain[SyncMsb];
      syncPrev[g] = prevQ;
      irqReq[g]   = irqEnable[g] &
                    ((strobes[g].levelSel & ~chain[SyncMsb]) |
                     (strobes[g].edgeSel & flagQ));
    end
  end

endmodule

// File: rtl/extint_sense.sv
module extint_sense
  import extint_pkg::*;
#(
  parameter int NumPins    = 2,
  parameter int SyncStages = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NumPins-1:0]     pinIn,
  input  logic [2*NumPins-1:0]   senseMode,
  input  logic [NumPins-1:0]     irqEnable,
  input  logic [NumPins-1:0]     irqAck,
  output logic [NumPins-1:0]     irqReq
);

  pinStrobe_t [NumPins-1:0] strobes;
  logic [NumPins-1:0]       syncNow;
  logic [NumPins-1:0]       syncPrev;

  extint_control #(.NumPins(NumPins)) u_ctrl (
    .senseMode(senseMode),
    .irqAck   (irqAck),
    .syncNow  (syncNow),
    .syncPrev (syncPrev),
    .strobes  (strobes)
  );

  extint_datapath #(.NumPins(NumPins), .SyncStages(SyncStages)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .pinIn    (pinIn),
    .irqEnable(irqEnable),
    .strobes  (strobes),
    .syncNow  (syncNow),
    .syncPrev (syncPrev),
    .irqReq   (irqReq)
  );

endmodule

// File: rtl/extint_sense_chk.sv
module extint_sense_chk #(
  parameter int NumPins = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NumPins-1:0]   pinIn,
  input logic [2*NumPins-1:0] senseMode,
  input logic [NumPins-1:0]   irqEnable,
  input logic [NumPins-1:0]   irqAck,
  input logic [NumPins-1:0]   irqReq
);

  // R1: quiet during reset
  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (irqReq == '0)
        else $error("R1 request during reset");
    end
  end

  for (genvar g = 0; g < NumPins; g++) begin : g_pin
    logic [1:0] m;
    logic       edgeMode;
    assign m        = senseMode[2*g +: 2];
    assign edgeMode = m[1];

    p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !irqEnable[g] |-> !irqReq[g]);

    p_reserved_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (m == 2'b01) |-> !irqReq[g]);

    p_edge_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (edgeMode && irqEnable[g] && irqReq[g] && !irqAck[g]) |=>
      (irqReq[g] || !irqEnable[g] || !edgeMode));

    p_level_high_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((m == 2'b00) && $past(pinIn[g], 1) && $past(pinIn[g], 2)) |-> !irqReq[g]);
  end

endmodule

bind extint_sense extint_sense_chk #(.NumPins(NumPins)) u_chk (.*);

// File: tb/sim_extint_sense.sv
`timescale 1ns/1ps
module sim_extint_sense;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pinIn = 2'b11;
  logic [3:0] senseMode = 4'b0000;
  logic [1:0] irqEnable = 2'b00;
  logic [1:0] irqAck = 2'b00;
  logic [1:0] irqReq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [1:0] exp;
    string      tag;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  extint_sense u0 (
    .clk(clk), .rst_n(rst_n), .pinIn(pinIn), .senseMode(senseMode),
    .irqEnable(irqEnable), .irqAck(irqAck), .irqReq(irqReq)
  );

  // Driver: after the next rising edge, irqReq is expected to be exp
  task automatic step(input logic [1:0] exp, input string tag);
    @(posedge clk);
    q.push_back('{exp: exp, tag: tag});
    @(negedge clk);
  endtask

  task automatic steps(input int n, input logic [1:0] exp, input string tag);
    for (int i = 0; i < n; i++) step(exp, tag);
  endtask

  // Monitor
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (irqReq !== it.exp) begin
        errors++;
        $display("FAIL %s actual %b expected %b at %0t", it.tag, irqReq, it.exp, $time);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: still in reset
    #1;
    checks++;
    if (irqReq !== 2'b00) begin
      errors++;
      $display("FAIL R1 actual %b expected 00", irqReq);
    end
    @(negedge clk);
    rst_n = 1'b1;
    steps(2, 2'b00, "R1");

    // R2 level mode on pin 0
    irqEnable = 2'b01;
    step(2'b00, "R2");
    pinIn[0] = 1'b0;
    step(2'b00, "R2");
    steps(3, 2'b01, "R2");
    // R11 ack has no effect in level mode
    irqAck[0] = 1'b1;
    step(2'b01, "R11");
    irqAck[0] = 1'b0;
    step(2'b01, "R11");
    pinIn[0] = 1'b1;
    step(2'b01, "R2");
    steps(2, 2'b00, "R2");

    // R3 falling mode on pin 0
    senseMode[1:0] = 2'b10;
    step(2'b00, "R3");
    pinIn[0] = 1'b0;
    steps(2, 2'b00, "R3");
    step(2'b01, "R3");
    pinIn[0] = 1'b1;
    steps(3, 2'b01, "R3");
    // R5 ack clears
    irqAck[0] = 1'b1;
    step(2'b00, "R5");
    irqAck[0] = 1'b0;
    step(2'b00, "R5");

    // R4 / R10 rising mode on pin 1
    senseMode[3:2] = 2'b11;
    irqEnable = 2'b11;
    step(2'b00, "R4");
    pinIn[1] = 1'b0;
    steps(4, 2'b00, "R10");
    pinIn[1] = 1'b1;
    steps(2, 2'b00, "R4");
    steps(2, 2'b10, "R4");

    // R9 independence
    pinIn[0] = 1'b0;
    steps(2, 2'b10, "R9");
    step(2'b11, "R9");
    irqAck[1] = 1'b1;
    step(2'b01, "R9");
    irqAck[1] = 1'b0;
    irqAck[0] = 1'b1;
    step(2'b00, "R5");
    irqAck[0] = 1'b0;
    pinIn[0] = 1'b1;
    steps(3, 2'b00, "R10");

    // R6 ack meets a new edge
    pinIn[0] = 1'b0;
    steps(2, 2'b00, "R6");
    irqAck[0] = 1'b1;
    step(2'b01, "R6");
    irqAck[0] = 1'b0;
    step(2'b01, "R6");
    irqAck[0] = 1'b1;
    step(2'b00, "R6");
    irqAck[0] = 1'b0;
    pinIn[0] = 1'b1;
    steps(3, 2'b00, "R10");

    // R7 reserved mode
    senseMode[1:0] = 2'b01;
    pinIn[0] = 1'b0;
    steps(3, 2'b00, "R7");
    pinIn[0] = 1'b1;
    steps(3, 2'b00, "R7");
    senseMode[1:0] = 2'b10;
    step(2'b00, "R7");

    // R8 disabled edge is latched
    irqEnable = 2'b10;
    pinIn[0] = 1'b0;
    steps(4, 2'b00, "R8");
    irqEnable = 2'b11;
    step(2'b01, "R8");
    irqAck[0] = 1'b1;
    step(2'b00, "R8");
    irqAck[0] = 1'b0;
    // R8 level mode gated
    senseMode[1:0] = 2'b00;
    irqEnable = 2'b10;
    step(2'b00, "R8");
    irqEnable = 2'b11;
    step(2'b01, "R8");
    pinIn[0] = 1'b1;
    step(2'b01, "R2");
    step(2'b00, "R2");

    @(negedge clk);
    wait (q.size() == 0);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule